// File: doc/BRIEF.md
# Fractional-Slot UART Baud Tick Generator

This block produces the 16x oversampling tick that a UART receiver and transmitter use to pace their bit timing, starting from a reference clock. A bit time consists of sixteen sample periods. Each period lasts a whole number of reference clocks, set by an integer divisor register. A 16-bit slot mask then lets any chosen period run one reference clock longer. This sets the effective divisor in steps of 1/16, so an awkward reference-to-baud ratio can be matched much more closely than an integer divider allows.

Software writes the divisor as the whole part of (reference rate / baud) / 16, minus one. It writes the slot mask with as many set bits as the remainder of (reference rate / baud) modulo 16. Well-spread masks place the longer periods evenly through the bit time; for example, 0x2222 for four extra clocks or 0xD5D5 for ten. A write is held in a shadow register and takes effect only at a period boundary, so no period is ever cut short or mixed between two settings. The slot-mask feature is optional: when it is built out, or when the mask is zero, the block is a plain integer divider.

The block has no data stream. Its writes are plain one-cycle strobes with no back-pressure, and its outputs are a tick pulse and the index of the sample period in progress.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, `tick` is 0 whatever the enable does. From the first clock edge of reset onward, `slot_idx` reads 0.
- R2: A sample period whose slot bit is clear lasts exactly divisor + 1 reference clocks. `tick` is high only in its final cycle.
- R3: A sample period whose slot index is N, with bit N of the slot mask set, lasts exactly divisor + 2 reference clocks. `tick` is high only in its final cycle.
- R4: `slot_idx` holds steady during a period. After a tick with no write pending, it advances by one, wrapping from 15 to 0. The first period after enable has index 0.
- R5: Over the 16 ticks that follow an enable, the total number of reference clocks equals 16 × (divisor + 1) + the number of set bits in the mask.
- R6: A register write made partway through a period does not change that period's length. The period finishes with the old divisor and mask, and `slot_idx` keeps its old value until that period's tick.
- R7: The period that follows a boundary with a write pending uses the new values and has `slot_idx` 0.
- R8: While the enable is low, no tick is produced. From the cycle after the enable is sampled low, `slot_idx` reads 0. The first period after the enable rises is a full period with index 0.
- R9: When the block is built with the slot feature absent (`HAS_SLOTS` = 0), mask writes are ignored. Every period lasts divisor + 1 clocks, even after the mask value 0xFFFF is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable; low holds counter and slot index at zero |
| div_wr | input | 1 | One-cycle strobe that writes `div_wdata` to the divisor shadow |
| div_wdata | input | DIV_W | New integer divisor (period length minus one) |
| mask_wr | input | 1 | One-cycle strobe that writes `mask_wdata` to the slot-mask shadow |
| mask_wdata | input | 16 | New slot mask; bit N stretches the period with index N |
| tick | output | 1 | One-cycle pulse in the final cycle of each sample period |
| slot_idx | output | 4 | Index (0 to 15) of the sample period in progress |

## Verification
On every cycle, the bound checker compares each period's length at its tick against the divisor and mask bit then active. It also confirms that the slot index stays steady within a period, steps or restarts correctly at each boundary, and falls silent while disabled. Other behaviours need a scenario to show them. The bench's scenarios cover the 16-period totals for many divisor and mask pairs, the wrap after the sixteenth tick, the exact period in which a mid-period write lands, and the plain-divider behaviour of a build without the slot feature.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int SLOT_N = 16;
  localparam int SLOT_W = $clog2(SLOT_N);
  typedef logic [SLOT_W-1:0] slot_idx_t;
  typedef logic [SLOT_N-1:0] slot_mask_t;
endpackage

// File: rtl/fbg_cfg_regs.sv
// Shadow and active configuration. Writes land in the shadow copy. The
// active copy is refreshed at a period boundary or while disabled.
module fbg_cfg_regs
  import fbg_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter bit HAS_SLOTS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             boundary,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             mask_wr,
  input  slot_mask_t       mask_wdata,
  output logic [DIV_W-1:0] act_div,
  output slot_mask_t       act_mask,
  output logic             restart
);
  localparam slot_mask_t SLOT_KEEP = HAS_SLOTS ? '1 : '0;

  logic [DIV_W-1:0] div_sh, div_nx;
  slot_mask_t       mask_sh, mask_nx;
  logic             pend, mask_hit;

  always_comb begin
    div_nx   = div_wr ? div_wdata : div_sh;
    mask_nx  = (mask_wr ? mask_wdata : mask_sh) & SLOT_KEEP;
    mask_hit = mask_wr & HAS_SLOTS;
    restart  = pend | div_wr | mask_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sh   <= '0;
      mask_sh  <= '0;
      act_div  <= '0;
      act_mask <= '0;
      pend     <= 1'b0;
    end else begin
      div_sh  <= div_nx;
      mask_sh <= mask_nx;
      if (!en || boundary) begin
        act_div  <= div_nx;
        act_mask <= mask_nx;
        pend     <= 1'b0;
      end else begin
        pend <= restart;
      end
    end
  end
endmodule

// File: rtl/fbg_period_ctr.sv
// Counts the reference clocks of one sample period; flags the final cycle.
module fbg_period_ctr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             stretch,
  output logic             last
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt, end_val;

  always_comb begin
    end_val = CNT_W'(div) + CNT_W'(stretch);
    last    = en && !rst && (cnt == end_val);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (last)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/fbg_slot_seq.sv
// Tracks which of the sixteen sample periods is in progress and selects
// its mask bit.
module fbg_slot_seq
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       restart,
  input  slot_mask_t mask,
  output slot_idx_t  slot,
  output logic       stretch
);
  assign stretch = mask[slot];

  always_ff @(posedge clk) begin
    if (rst || !en)   slot <= '0;
    else if (tick)    slot <= restart ? slot_idx_t'(0) : slot + slot_idx_t'(1);
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter bit HAS_SLOTS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             mask_wr,
  input  logic [15:0]      mask_wdata,
  output logic             tick,
  output logic [3:0]       slot_idx
);
  logic [DIV_W-1:0] act_div;
  slot_mask_t       act_mask;
  logic             restart, stretch;
  slot_idx_t        slot;

  fbg_cfg_regs #(.DIV_W(DIV_W), .HAS_SLOTS(HAS_SLOTS)) cfg_i (
    .clk(clk), .rst(rst), .en(en), .boundary(tick),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .act_div(act_div), .act_mask(act_mask), .restart(restart)
  );

  fbg_period_ctr #(.DIV_W(DIV_W)) ctr_i (
    .clk(clk), .rst(rst), .en(en), .div(act_div),
    .stretch(stretch), .last(tick)
  );

  fbg_slot_seq seq_i (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .restart(restart),
    .mask(act_mask), .slot(slot), .stretch(stretch)
  );

  assign slot_idx = slot;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int DIV_W     = 16,
  parameter bit HAS_SLOTS = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             div_wr,
  input logic             mask_wr,
  input logic             tick,
  input logic [3:0]       slot_idx,
  input logic [DIV_W-1:0] act_div,
  input logic [15:0]      act_mask
);
  localparam int LW = DIV_W + 2;

  logic [LW-1:0] len_ctr;
  logic          wr_seen, wr_any;

  assign wr_any = wr_seen | div_wr | (mask_wr & HAS_SLOTS);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) len_ctr <= '0;
    else                    len_ctr <= len_ctr + LW'(1);
    if (rst || !en || tick) wr_seen <= 1'b0;
    else                    wr_seen <= wr_any;
  end

  // R2 and R3: period length at its tick matches the active settings
  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (len_ctr + LW'(1)) == (LW'(act_div) + LW'(1) + LW'(act_mask[slot_idx])));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> (!en || slot_idx == $past(slot_idx)));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !wr_any) |=> (!en || slot_idx == $past(slot_idx) + 4'd1));

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && wr_any) |=> (!en || slot_idx == 4'd0));

  p_idle_tick_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);

  p_idle_slot_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> slot_idx == 4'd0);
endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(DIV_W), .HAS_SLOTS(HAS_SLOTS)) chk_i (
  .clk(clk), .rst(rst), .en(en), .div_wr(div_wr), .mask_wr(mask_wr),
  .tick(tick), .slot_idx(slot_idx), .act_div(act_div), .act_mask(act_mask)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
  localparam int DIV_W = 16;
  localparam int NVEC  = 10;
  // {divisor, slot mask, expected clocks over 16 ticks}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd0, 16'h0000, 16'd16},
    {16'd1, 16'h0080, 16'd33},
    {16'd2, 16'h0808, 16'd50},
    {16'd3, 16'h2222, 16'd68},
    {16'd4, 16'h4924, 16'd85},
    {16'd5, 16'h5555, 16'd104},
    {16'd6, 16'hD5D5, 16'd122},
    {16'd2, 16'hFFDF, 16'd63},
    {16'd0, 16'hFFFF, 16'd32},
    {16'd7, 16'h4A52, 16'd134}
  };

  logic clk = 1'b0;
  logic rst, en, div_wr, mask_wr;
  logic [DIV_W-1:0] div_wdata;
  logic [15:0] mask_wdata;
  logic tick, tick_p;
  logic [3:0] slot_idx, slot_p;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_baud_gen #(.DIV_W(DIV_W), .HAS_SLOTS(1'b1)) dut_i (
    .clk(clk), .rst(rst), .en(en), .div_wr(div_wr), .div_wdata(div_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .tick(tick), .slot_idx(slot_idx));

  frac_baud_gen #(.DIV_W(DIV_W), .HAS_SLOTS(1'b0)) dut_plain_i (
    .clk(clk), .rst(rst), .en(en), .div_wr(div_wr), .div_wdata(div_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .tick(tick_p), .slot_idx(slot_p));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int d, input int m);
    @(negedge clk);
    div_wr = 1'b1; mask_wr = 1'b1;
    div_wdata = DIV_W'(d); mask_wdata = 16'(m);
    @(negedge clk);
    div_wr = 1'b0; mask_wr = 1'b0;
  endtask

  // Called at a mid-cycle sample point; returns after the tick cycle.
  task automatic next_tick(output int len, output int s);
    len = 0; s = -1;
    for (int g = 0; g < 2000; g++) begin
      len++;
      if (tick) begin
        s = int'(slot_idx);
        @(negedge clk); #1;
        return;
      end
      @(negedge clk); #1;
    end
    len = -1;
  endtask

  task automatic start_run(input int d, input int m);
    @(negedge clk); en = 1'b0;
    write_cfg(d, m);
    @(negedge clk); en = 1'b1; #1;
  endtask

  initial begin
    int len, s, total, cnt_a, cnt_p;
    rst = 1'b1; en = 1'b1; div_wr = 0; mask_wr = 0; div_wdata = '0; mask_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    chk(slot_idx == 4'd0, "R1 slot in reset", int'(slot_idx), 0);
    @(negedge clk); en = 1'b0; rst = 1'b0;

    // Table of divisor/mask pairs: per-period lengths, indices, totals
    for (int i = 0; i < NVEC; i++) begin
      int d, m, exp_tot;
      d = int'(VEC[i][47:32]); m = int'(VEC[i][31:16]); exp_tot = int'(VEC[i][15:0]);
      start_run(d, m);
      total = 0;
      for (int k = 0; k < 16; k++) begin
        next_tick(len, s);
        if (m[k]) chk(len == d + 2, "R3 stretched period", len, d + 2);
        else      chk(len == d + 1, "R2 plain period", len, d + 1);
        chk(s == k, "R4 slot index", s, k);
        total += len;
      end
      chk(total == exp_tot, "R5 sixteen-period total", total, exp_tot);
    end

    // R4: wrap from 15 back to 0
    start_run(0, 0);
    for (int k = 0; k < 20; k++) begin
      next_tick(len, s);
      chk(s == (k % 16), "R4 wrap", s, k % 16);
      chk(len == 1, "R2 divisor zero", len, 1);
    end

    // R6 / R7: write in the middle of a period
    start_run(3, 0);
    for (int k = 0; k < 5; k++) next_tick(len, s);
    div_wr = 1'b1; mask_wr = 1'b1; div_wdata = DIV_W'(1); mask_wdata = 16'h0001;
    fork begin @(negedge clk); div_wr = 1'b0; mask_wr = 1'b0; end join_none
    next_tick(len, s);
    chk(len == 4, "R6 old period length kept", len, 4);
    chk(s == 5, "R6 old slot index kept", s, 5);
    next_tick(len, s);
    chk(s == 0, "R7 slot restart", s, 0);
    chk(len == 3, "R7 new divisor and mask", len, 3);
    next_tick(len, s);
    chk(s == 1, "R7 slot after restart", s, 1);
    chk(len == 2, "R7 new divisor", len, 2);

    // R8: disable mid-run, stay idle, re-enable
    next_tick(len, s);
    en = 1'b0; #1;
    chk(tick == 1'b0, "R8 no tick on disable", int'(tick), 0);
    cnt_a = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      if (tick || slot_idx != 4'd0) cnt_a++;
    end
    chk(cnt_a == 0, "R8 idle cycles with activity", cnt_a, 0);
    en = 1'b1; #1;
    next_tick(len, s);
    chk(s == 0, "R8 first index after enable", s, 0);
    chk(len == 3, "R8 full first period", len, 3);

    // R9: build without slots ignores the mask
    start_run(2, 16'hFFFF);
    cnt_a = 0; cnt_p = 0;
    for (int k = 0; k < 48; k++) begin
      if (tick) cnt_a++;
      if (tick_p) cnt_p++;
      @(negedge clk); #1;
    end
    chk(cnt_p == 16, "R9 plain build tick count", cnt_p, 16);
    chk(cnt_a == 12, "R3 slot build tick count", cnt_a, 12);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule